// File: doc/BRIEF.md
# Key-Protected Control Register Bank

This block is a bank of 16-bit control registers on a simple synchronous register bus. A write command carries a start address, a word count and up to four data words, and it commits all of its words in one clock cycle. A read command returns one word, one cycle after it is presented. Each register has its own writable-bit mask and readable-bit mask. A read returns only the readable bits. A write changes only the writable bits and leaves every other bit as it was.

Address 0 holds a security word, and this word gates writes to two guarded ranges. The guarded ranges are four pin-function registers and three charge-control registers. They accept writes only while the security word equals the open key 0x0013. Writing 0x0000, or any other value, closes them again. Any request that breaks a rule is refused as a whole and raises an error flag for one cycle. The rules cover out-of-range addresses, read-only registers and guarded registers while closed.

Top module: `keyreg_bank`

## Requirements
- R1: Reset state. The security word (address 0) is 0x0000, so the bank is closed. Address 1 holds 0x6143, address 2 holds 0x1234, and every other address i holds {i[7:0], i[7:0]}. busErr and busRdata are 0.
- R2: An accepted read (busRead=1, busWrite=0, address below 32) returns the register ANDed with its read mask on busRdata one cycle later. The read mask is 0x00FF at address 2 and 0xFF0F at every address i>=3 with i divisible by 3. It is 0xFFFF everywhere else.
- R3: An accepted write stores only the bits in the register's write mask. Other bits keep their value. The write mask is 0xFFFF at address 0, 0x0000 at addresses 1 and 2, 0x0FFF at odd addresses from 3 up, and 0xFFFF at even addresses from 4 up.
- R4: A write that touches a register whose write mask is zero is refused.
- R5: A read at address 32 or above is refused, and busRdata is 0 in the next cycle. A write whose last word (start + busLen) lies at 32 or above is also refused.
- R6: While the security word differs from 0x0013, writes to addresses 8..11 and 20..22 are refused. The lock decision uses the security word as it stood before the request.
- R7: The security word accepts writes in either state. Writing 0x0013 opens the guarded ranges. Writing any other value, such as 0x0000 or 0x0012, keeps or puts them closed.
- R8: A refused request changes no register, and busErr is 1 in the cycle after it. busErr is 0 after an accepted request and after an idle cycle.
- R9: A write covers busLen+1 consecutive addresses, with word k taken from busWdata[16k+15:16k]. If any word in it breaks a rule, no word is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 6 | Start address of the request |
| busLen | input | 2 | Word count minus one for a write |
| busWdata | input | 64 | Write words, word k in bits 16k+15:16k |
| busWrite | input | 1 | Write request, takes priority over a read |
| busRead | input | 1 | Read request |
| busRdata | output | 16 | Masked read data, one cycle after the read |
| busErr | output | 1 | One-cycle refusal flag |

## Verification
The bench targets the points where a key check is easy to get wrong. Values one step from the open key must leave the bank closed. A burst that is refused must not store its first words before the bad word is found. The last word of a burst must be range-checked as well as its first. A design that compared only part of the key, or that committed burst words one by one, would leave altered registers behind, and the read-backs would expose them. Masked read-backs of mixed-mask registers catch a design that applies the write mask to reads, or that applies no mask at all.

// File: rtl/keyreg_pkg.sv
`timescale 1ns/1ps
package keyreg_pkg;
  localparam int DATA_W = 16;
  localparam int SEC_ADDR = 0;

  typedef struct packed {
    logic commit;
    logic readHit;
    logic fault;
  } ctrlStrobes_t;

  function automatic logic [DATA_W-1:0] resetOf(input int idx);
    logic [7:0] b;
    b = 8'(idx);
    if (idx == SEC_ADDR) return '0;
    if (idx == 1) return 16'h6143;
    if (idx == 2) return 16'h1234;
    return {b, b};
  endfunction

  function automatic logic [DATA_W-1:0] wrMaskOf(input int idx);
    if (idx == SEC_ADDR) return 16'hFFFF;
    if (idx == 1 || idx == 2) return 16'h0000;
    if (idx % 2 == 1) return 16'h0FFF;
    return 16'hFFFF;
  endfunction

  function automatic logic [DATA_W-1:0] rdMaskOf(input int idx);
    if (idx == 2) return 16'h00FF;
    if (idx >= 3 && idx % 3 == 0) return 16'hFF0F;
    return 16'hFFFF;
  endfunction
endpackage

// File: rtl/keyreg_ctrl.sv
`timescale 1ns/1ps
module keyreg_ctrl
  import keyreg_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int ADDR_W = 6,
  parameter int MAX_BURST = 4,
  parameter int LEN_W = 2,
  parameter int GPIO_BASE = 8,
  parameter int GPIO_CNT = 4,
  parameter int CHG_BASE = 20,
  parameter int CHG_CNT = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [LEN_W-1:0]  busLen,
  input  logic              busWrite,
  input  logic              busRead,
  input  logic              unlocked,
  output ctrlStrobes_t      strobes,
  output logic              errQ
);
  localparam logic [ADDR_W:0] NUM_W   = (ADDR_W+1)'(NUM_REGS);
  localparam logic [ADDR_W:0] GPIO_LO = (ADDR_W+1)'(GPIO_BASE);
  localparam logic [ADDR_W:0] GPIO_HI = (ADDR_W+1)'(GPIO_BASE + GPIO_CNT);
  localparam logic [ADDR_W:0] CHG_LO  = (ADDR_W+1)'(CHG_BASE);
  localparam logic [ADDR_W:0] CHG_HI  = (ADDR_W+1)'(CHG_BASE + CHG_CNT);

  function automatic logic isGuarded(input logic [ADDR_W:0] a);
    return (a >= GPIO_LO && a < GPIO_HI) || (a >= CHG_LO && a < CHG_HI);
  endfunction

  logic [MAX_BURST-1:0] wordBad;
  logic                 readInRange;

  for (genvar k = 0; k < MAX_BURST; k++) begin : g_word
    logic [ADDR_W:0] wordAddr;
    logic            inBurst;
    assign wordAddr = {1'b0, busAddr} + (ADDR_W+1)'(k);
    assign inBurst  = LEN_W'(k) <= busLen;
    assign wordBad[k] = inBurst &&
                        (wordAddr >= NUM_W ||
                         wrMaskOf(int'(wordAddr)) == '0 ||
                         (!unlocked && isGuarded(wordAddr)));
  end

  assign readInRange = {1'b0, busAddr} < NUM_W;

  always_comb begin
    strobes.commit  = busWrite && !(|wordBad);
    strobes.readHit = !busWrite && busRead && readInRange;
    strobes.fault   = (busWrite && (|wordBad)) ||
                      (!busWrite && busRead && !readInRange);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) errQ <= 1'b0;
    else       errQ <= strobes.fault;
  end
endmodule

// File: rtl/keyreg_data.sv
`timescale 1ns/1ps
module keyreg_data
  import keyreg_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int ADDR_W = 6,
  parameter int MAX_BURST = 4,
  parameter int LEN_W = 2,
  parameter logic [DATA_W-1:0] UNLOCK_KEY = 16'h0013
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [ADDR_W-1:0]           busAddr,
  input  logic [LEN_W-1:0]            busLen,
  input  logic [MAX_BURST*DATA_W-1:0] busWdata,
  input  ctrlStrobes_t                strobes,
  output logic [DATA_W-1:0]           rdataQ,
  output logic                        unlocked
);
  localparam int IDX_W = $clog2(NUM_REGS);

  logic [DATA_W-1:0] regArr [NUM_REGS];
  logic [ADDR_W:0]   wordAddr [MAX_BURST];

  always_comb begin
    for (int k = 0; k < MAX_BURST; k++)
      wordAddr[k] = {1'b0, busAddr} + (ADDR_W+1)'(k);
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [DATA_W-1:0] WM = wrMaskOf(i);
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        q <= resetOf(i);
      end else if (strobes.commit) begin
        for (int k = 0; k < MAX_BURST; k++) begin
          if (LEN_W'(k) <= busLen && wordAddr[k] == (ADDR_W+1)'(i))
            q <= (q & ~WM) | (busWdata[k*DATA_W +: DATA_W] & WM);
        end
      end
    end
    assign regArr[i] = q;
  end

  assign unlocked = regArr[SEC_ADDR] == UNLOCK_KEY;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      rdataQ <= '0;
    else if (strobes.readHit)
      rdataQ <= regArr[busAddr[IDX_W-1:0]] & rdMaskOf(int'(busAddr));
    else
      rdataQ <= '0;
  end
endmodule

// File: rtl/keyreg_bank.sv
`timescale 1ns/1ps
module keyreg_bank
  import keyreg_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int ADDR_W = 6,
  parameter int MAX_BURST = 4,
  parameter int GPIO_BASE = 8,
  parameter int GPIO_CNT = 4,
  parameter int CHG_BASE = 20,
  parameter int CHG_CNT = 3,
  parameter logic [15:0] UNLOCK_KEY = 16'h0013,
  localparam int LEN_W = (MAX_BURST > 1) ? $clog2(MAX_BURST) : 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [ADDR_W-1:0]           busAddr,
  input  logic [LEN_W-1:0]            busLen,
  input  logic [MAX_BURST*DATA_W-1:0] busWdata,
  input  logic                        busWrite,
  input  logic                        busRead,
  output logic [DATA_W-1:0]           busRdata,
  output logic                        busErr
);
  ctrlStrobes_t strobes;
  logic         unlocked;

  keyreg_ctrl #(
    .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .MAX_BURST(MAX_BURST), .LEN_W(LEN_W),
    .GPIO_BASE(GPIO_BASE), .GPIO_CNT(GPIO_CNT), .CHG_BASE(CHG_BASE), .CHG_CNT(CHG_CNT)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busLen(busLen),
    .busWrite(busWrite), .busRead(busRead), .unlocked(unlocked),
    .strobes(strobes), .errQ(busErr)
  );

  keyreg_data #(
    .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .MAX_BURST(MAX_BURST), .LEN_W(LEN_W),
    .UNLOCK_KEY(UNLOCK_KEY)
  ) data_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busLen(busLen),
    .busWdata(busWdata), .strobes(strobes), .rdataQ(busRdata), .unlocked(unlocked)
  );
endmodule

// File: rtl/keyreg_bank_chk.sv
`timescale 1ns/1ps
module keyreg_bank_chk #(
  parameter int NUM_REGS = 32,
  parameter int ADDR_W = 6,
  parameter int MAX_BURST = 4,
  parameter int LEN_W = 2,
  parameter int GPIO_BASE = 8,
  parameter int GPIO_CNT = 4,
  parameter logic [15:0] UNLOCK_KEY = 16'h0013
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [ADDR_W-1:0]     busAddr,
  input logic [LEN_W-1:0]      busLen,
  input logic [MAX_BURST*16-1:0] busWdata,
  input logic                  busWrite,
  input logic                  busRead,
  input logic [15:0]           busRdata,
  input logic                  busErr,
  input logic                  unlocked
);
  localparam logic [ADDR_W:0] NUM_W   = (ADDR_W+1)'(NUM_REGS);
  localparam logic [ADDR_W:0] GPIO_LO = (ADDR_W+1)'(GPIO_BASE);
  localparam logic [ADDR_W:0] GPIO_HI = (ADDR_W+1)'(GPIO_BASE + GPIO_CNT);

  assert_err_needs_req_R8: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> $past(busWrite || busRead));

  assert_refused_keeps_lock_R8: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> $stable(unlocked));

  assert_oob_read_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busRead && !busWrite && {1'b0, busAddr} >= NUM_W) |=> (busErr && busRdata == '0));

  assert_readonly_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && (busAddr == ADDR_W'(1) || busAddr == ADDR_W'(2))) |=> busErr);

  assert_closed_guard_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && !unlocked && {1'b0, busAddr} >= GPIO_LO && {1'b0, busAddr} < GPIO_HI)
      |=> busErr);

  assert_key_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && busLen == '0 && busAddr == '0)
      |=> (!busErr && unlocked == ($past(busWdata[15:0]) == UNLOCK_KEY)));

  assert_read_mask_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busRead && !busWrite && busAddr == ADDR_W'(2)) |=> busRdata[15:8] == 8'h00);
endmodule

bind keyreg_bank keyreg_bank_chk #(
  .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .MAX_BURST(MAX_BURST), .LEN_W(LEN_W),
  .GPIO_BASE(GPIO_BASE), .GPIO_CNT(GPIO_CNT), .UNLOCK_KEY(UNLOCK_KEY)
) chk_i (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busLen(busLen), .busWdata(busWdata),
  .busWrite(busWrite), .busRead(busRead), .busRdata(busRdata), .busErr(busErr),
  .unlocked(unlocked)
);

// File: tb/keyreg_bank_tb_top.sv
`timescale 1ns/1ps
module keyreg_bank_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [1:0]  busLen = '0;
  logic [63:0] busWdata = '0;
  logic        busWrite = 1'b0;
  logic        busRead = 1'b0;
  logic [15:0] busRdata;
  logic        busErr;

  int errors = 0;
  int checks = 0;
  logic finished = 1'b0;

  always #2 clk = ~clk;

  keyreg_bank dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busLen(busLen), .busWdata(busWdata),
    .busWrite(busWrite), .busRead(busRead), .busRdata(busRdata), .busErr(busErr)
  );

  typedef struct {
    logic        isRead;
    logic [15:0] rdata;
    logic        err;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  logic [15:0] model [32];

  // Expected masks and reset values, taken from R1..R3
  function automatic logic [15:0] tbRst(int i);
    if (i == 0) return 16'h0000;
    if (i == 1) return 16'h6143;
    if (i == 2) return 16'h1234;
    return {8'(i), 8'(i)};
  endfunction
  function automatic logic [15:0] tbWm(int i);
    if (i == 0) return 16'hFFFF;
    if (i == 1 || i == 2) return 16'h0000;
    return (i % 2 == 1) ? 16'h0FFF : 16'hFFFF;
  endfunction
  function automatic logic [15:0] tbRm(int i);
    if (i == 2) return 16'h00FF;
    if (i >= 3 && i % 3 == 0) return 16'hFF0F;
    return 16'hFFFF;
  endfunction
  function automatic logic guarded(int a);
    return (a >= 8 && a <= 11) || (a >= 20 && a <= 22);
  endfunction

  task automatic check(logic ok, string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doWrite(int addr, int len, logic [63:0] data, string tag);
    logic bad;
    logic closed;
    expItem_t it;
    bad = 1'b0;
    closed = model[0] != 16'h0013;
    for (int k = 0; k <= len; k++) begin
      int a;
      a = addr + k;
      if (a >= 32) bad = 1'b1;
      else if (tbWm(a) == 16'h0000) bad = 1'b1;
      else if (closed && guarded(a)) bad = 1'b1;
    end
    if (!bad) begin
      for (int k = 0; k <= len; k++) begin
        int a;
        a = addr + k;
        model[a] = (model[a] & ~tbWm(a)) | (data[k*16 +: 16] & tbWm(a));
      end
    end
    @(negedge clk);
    busAddr = 6'(addr); busLen = 2'(len); busWdata = data;
    busWrite = 1'b1; busRead = 1'b0;
    it.isRead = 1'b0; it.rdata = '0; it.err = bad; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic doRead(int addr, string tag);
    expItem_t it;
    @(negedge clk);
    busAddr = 6'(addr); busLen = '0; busWrite = 1'b0; busRead = 1'b1;
    it.isRead = 1'b1;
    it.err = addr >= 32;
    it.rdata = (addr >= 32) ? 16'h0000 : (model[addr] & tbRm(addr));
    it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic idle(int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      busWrite = 1'b0; busRead = 1'b0;
    end
  endtask

  // Monitor: results appear one cycle after the request
  logic reqSeen = 1'b0;
  always @(posedge clk) reqSeen <= rstN && (busWrite || busRead);

  always @(negedge clk) begin
    if (reqSeen && !finished) begin
      if (expQ.size() == 0) begin
        check(1'b0, "scoreboard underflow", 16'h0, 16'h0);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        check(busErr == it.err, {it.tag, " err"}, {15'h0, busErr}, {15'h0, it.err});
        if (it.isRead)
          check(busRdata == it.rdata, {it.tag, " rdata"}, busRdata, it.rdata);
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%h expected=%h", 16'h0, 16'h1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = tbRst(i);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(busErr == 1'b0, "R1 reset err", {15'h0, busErr}, 16'h0);
    check(busRdata == 16'h0, "R1 reset rdata", busRdata, 16'h0);

    doRead(0, "R1 security reset");
    doRead(1, "R1 id reset");
    doRead(2, "R2 mask addr2");
    doRead(3, "R2 mask addr3");
    doRead(9, "R2 mask addr9");
    doRead(31, "R1 top reset");

    doWrite(5, 0, 64'hFFFF, "R3 masked write");
    doRead(5, "R3 readback");
    doWrite(4, 0, 64'hBEEF, "R3 full write");
    doRead(4, "R3 full readback");

    doWrite(1, 0, 64'h0000, "R4 readonly write");
    doRead(1, "R8 readonly unchanged");

    doWrite(9, 0, 64'h5555, "R6 closed gpio");
    doRead(9, "R8 gpio unchanged");
    doWrite(21, 0, 64'h5555, "R6 closed charger");
    doRead(21, "R8 charger unchanged");

    doWrite(0, 0, 64'h0012, "R7 near key");
    doWrite(10, 0, 64'h1111, "R7 still closed");
    doRead(10, "R7 closed unchanged");

    doWrite(0, 0, 64'h0013, "R7 open key");
    doWrite(9, 0, 64'hABCD, "R6 open gpio");
    doRead(9, "R6 open readback");

    doWrite(6, 3, 64'h4444_3333_2222_1111, "R9 burst ok");
    doRead(6, "R9 word0");
    doRead(7, "R9 word1");
    doRead(8, "R9 word2");
    doRead(9, "R9 word3");

    doWrite(0, 1, 64'h0000_0000_0000_0000, "R9 burst readonly");
    doRead(0, "R9 key kept");

    doWrite(29, 3, 64'h9999_8888_7777_6666, "R5 burst past end");
    doRead(29, "R9 no partial");
    doRead(31, "R9 no partial top");

    doWrite(0, 0, 64'h0000, "R7 close key");
    doWrite(19, 3, 64'hAAAA_BBBB_CCCC_DDDD, "R6 burst into guard");
    doRead(19, "R9 lead word kept");
    doRead(20, "R6 guard kept");

    doRead(40, "R5 read out of range");
    doWrite(63, 0, 64'h1, "R5 write out of range");
    idle(1);
    doRead(2, "R2 addr2 again");
    idle(3);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule